// File: doc/BRIEF.md
# Atomic Set/Clear/Toggle Control Register with Self-Timed Reset

This block is one 32-bit control/status word for a peripheral. A small word bus reaches it through four aliases chosen by a 2-bit word offset. Offset 0 loads the word outright. Offset 1 ORs bits in, offset 2 removes bits, and offset 3 flips bits. Software can therefore change one field without a read-modify-write. Reads at any alias return the stored word, combinationally, in the same cycle as the read strobe.

The two top bits run the peripheral. Bit 31 is a soft reset and drives the core reset output directly. While it is 1, bits 29:0 are held at zero. Bit 30 is a clock gate, and the clock-enable output is its inverse. Once soft reset has been held for a programmable number of clock edges, the block sets the clock-gate bit by itself, a single time for each assertion. Software polls for that bit to learn that the internal reset has finished. It then clears soft reset, followed by the clock gate, to bring the peripheral back.

Top module: `sct_ctrl_reg`

## Requirements
- R1: After reset the register reads 0, `core_clk_en` is 1 and `core_rst` is 0.
- R2: A write with `bus_addr` = 0 (byte offset 0x0) loads `bus_wdata` into the register.
- R3: A write with `bus_addr` = 1 (byte offset 0x4) ORs `bus_wdata` into the register.
- R4: A write with `bus_addr` = 2 (byte offset 0x8) clears each register bit that is 1 in `bus_wdata`.
- R5: A write with `bus_addr` = 3 (byte offset 0xC) inverts each register bit that is 1 in `bus_wdata`.
- R6: With no write and no hardware event, the register keeps its value.
- R7: While `bus_rd` is 1, `bus_rdata` equals the register in that same cycle, whatever the alias. While `bus_rd` is 0, `bus_rdata` is 0.
- R8: `core_rst` equals bit 31 (soft reset).
- R9: While bit 31 is 1, bits 29:0 read 0, and writes to them have no effect.
- R10: Bit 30 (clock gate) is set by hardware on the GATE_DELAY-th clock edge after the edge that set bit 31. It is not set earlier, and it is set only once per soft-reset assertion. If software clears it while bit 31 stays 1, it remains clear.
- R11: `core_clk_en` is the inverse of bit 30.
- R12: Clearing bit 31 and then bit 30 gives `core_rst` = 0 and `core_clk_en` = 1, and bits 29:0 become writable again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Word offset: 0 write, 1 set, 2 clear, 3 toggle |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data or bit mask |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read data, zero when not reading |
| core_clk_en | output | 1 | Peripheral clock enable |
| core_rst | output | 1 | Peripheral core reset |

## Verification
The register, `core_rst` and `core_clk_en` change at the clock edge that takes a write. The bench drives each write on a falling edge and samples every result on the following falling edge, so one register stage lies between them. `bus_rdata` has no register in its path: the bench raises `bus_rd` on a falling edge and compares 1 ns later. The hardware clock-gate set is timed by sampling at consecutive falling edges. Sample j after the write that sets soft reset expects bit 30 to be 1 only when j is at least GATE_DELAY. A free-running bench model steps on every rising edge and supplies the expected word for the random writes.

// File: rtl/sct_pkg.sv
`timescale 1ns/1ps
package sct_pkg;
   typedef enum logic [1:0] {
      ALIAS_WRITE  = 2'd0,
      ALIAS_SET    = 2'd1,
      ALIAS_CLEAR  = 2'd2,
      ALIAS_TOGGLE = 2'd3
   } alias_e;
endpackage

// File: rtl/sct_alias_decode.sv
`timescale 1ns/1ps
module sct_alias_decode #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              wr,
   input  sct_pkg::alias_e   sel,
   input  logic [DATA_W-1:0] cur,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] nxt
);
   import sct_pkg::*;

   if (DATA_W < 3) begin : g_bad_width
      $error("sct_alias_decode: DATA_W must be at least 3");
   end

   always_comb begin
      nxt = cur;
      if (wr) begin
         case (sel)
            ALIAS_WRITE:  nxt = wdata;
            ALIAS_SET:    nxt = cur | wdata;
            ALIAS_CLEAR:  nxt = cur & ~wdata;
            ALIAS_TOGGLE: nxt = cur ^ wdata;
            default:      nxt = cur;
         endcase
      end
   end
endmodule

// File: rtl/sct_gate_timer.sv
`timescale 1ns/1ps
module sct_gate_timer #(
   parameter int unsigned DELAY = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic srst_on,
   output logic fire
);
   if (DELAY < 1) begin : g_bad_delay
      $error("sct_gate_timer: DELAY must be at least 1");
   end

   if (DELAY == 1) begin : g_flag
      logic seen_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) seen_q <= 1'b0;
         else        seen_q <= srst_on;
      end
      assign fire = srst_on & ~seen_q;
   end else begin : g_count
      localparam int CW = $clog2(DELAY + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                     cnt_q <= '0;
         else if (!srst_on)              cnt_q <= '0;
         else if (cnt_q != CW'(DELAY))   cnt_q <= cnt_q + 1'b1;
      end
      assign fire = srst_on && (cnt_q == CW'(DELAY - 1));
   end
endmodule

// File: rtl/sct_ctrl_reg.sv
`timescale 1ns/1ps
module sct_ctrl_reg #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned GATE_DELAY = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              core_clk_en,
   output logic              core_rst
);
   import sct_pkg::*;

   localparam int SRST_BIT = DATA_W - 1;
   localparam int GATE_BIT = DATA_W - 2;
   localparam logic [DATA_W-1:0] GATE_MASK = {{1'b0}, {1'b1}, {(DATA_W-2){1'b0}}};

   if (DATA_W < 3) begin : g_bad_width
      $error("sct_ctrl_reg: DATA_W must be at least 3");
   end

   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] sw_nxt;
   logic [DATA_W-1:0] hw_nxt;
   logic              fire;
   alias_e            sel;

   assign sel = alias_e'(bus_addr);

   sct_alias_decode #(.DATA_W(DATA_W)) u_decode (
      .wr    (bus_wr),
      .sel   (sel),
      .cur   (ctrl_q),
      .wdata (bus_wdata),
      .nxt   (sw_nxt)
   );

   sct_gate_timer #(.DELAY(GATE_DELAY)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .srst_on (ctrl_q[SRST_BIT]),
      .fire    (fire)
   );

   always_comb begin
      hw_nxt = sw_nxt;
      if (fire) hw_nxt[GATE_BIT] = 1'b1;
      if (hw_nxt[SRST_BIT]) hw_nxt[GATE_BIT-1:0] = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q <= '0;
      else        ctrl_q <= hw_nxt;
   end

   assign bus_rdata   = bus_rd ? ctrl_q : '0;
   assign core_rst    = ctrl_q[SRST_BIT];
   assign core_clk_en = ~ctrl_q[GATE_BIT];

   a_r2_plain_load: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == ALIAS_WRITE && !bus_wdata[SRST_BIT] && !fire)
      |=> (ctrl_q == $past(bus_wdata)));

   a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == ALIAS_SET && !ctrl_q[SRST_BIT] && !bus_wdata[SRST_BIT])
      |=> ((ctrl_q & $past(bus_wdata)) == $past(bus_wdata)));

   a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == ALIAS_CLEAR)
      |=> ((ctrl_q & $past(bus_wdata) & ~GATE_MASK) == '0));

   a_r5_toggle_bits: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && sel == ALIAS_TOGGLE && !ctrl_q[SRST_BIT] && !bus_wdata[SRST_BIT] && !fire)
      |=> (ctrl_q == ($past(ctrl_q) ^ $past(bus_wdata))));

   a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr && !fire) |=> $stable(ctrl_q));

   a_r9_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[SRST_BIT] |-> (ctrl_q[GATE_BIT-1:0] == '0));

   a_r10_gate_after_fire: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> ctrl_q[GATE_BIT]);

   a_r10_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
endmodule

// File: tb/tb_sct_ctrl_reg.sv
`timescale 1ns/1ps
module tb_sct_ctrl_reg;
   localparam int GD = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = 32'd0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        core_clk_en;
   logic        core_rst;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] exp_reg = 32'd0;
   int          age = 0;

   always #2 clk = ~clk;

   sct_ctrl_reg #(.DATA_W(32), .GATE_DELAY(GD)) dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .core_clk_en(core_clk_en), .core_rst(core_rst)
   );

   function automatic logic [31:0] apply_op(logic [31:0] cur, logic [1:0] a, logic [31:0] d);
      case (a)
         2'd0:    return d;
         2'd1:    return cur | d;
         2'd2:    return cur & ~d;
         default: return cur ^ d;
      endcase
   endfunction

   // reference model, stepping on every rising edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_reg <= 32'd0;
         age     <= 0;
      end else begin
         logic [31:0] n;
         n = bus_wr ? apply_op(exp_reg, bus_addr, bus_wdata) : exp_reg;
         if (exp_reg[31] && age == GD - 1) n[30] = 1'b1;
         if (n[31]) n[29:0] = 30'd0;
         exp_reg <= n;
         age     <= exp_reg[31] ? ((age < GD) ? age + 1 : age) : 0;
      end
   end

   task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %h exp %h", tag, got, exp);
      end
   endtask

   task automatic wr_op(logic [1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   // read at a falling edge and compare to the model
   task automatic rd_chk(string tag);
      @(negedge clk);
      bus_addr = 2'($urandom_range(0, 3));
      bus_rd = 1'b1;
      #1;
      chk(tag, bus_rdata, exp_reg);
      chk("R8 core_rst", {31'd0, core_rst}, {31'd0, exp_reg[31]});
      chk("R11 core_clk_en", {31'd0, core_clk_en}, {31'd0, ~exp_reg[30]});
      bus_rd = 1'b0;
   endtask

   initial begin
      #(4 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog got timeout exp finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1357));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      @(negedge clk);
      bus_rd = 1'b1; #1;
      chk("R1 rdata", bus_rdata, 32'd0);
      chk("R1 clk_en", {31'd0, core_clk_en}, 32'd1);
      chk("R1 core_rst", {31'd0, core_rst}, 32'd0);
      bus_rd = 1'b0;

      // R2..R5 directed
      wr_op(2'd0, 32'h0000_F0F0); rd_chk("R2");
      chk("R2 literal", exp_reg, 32'h0000_F0F0);
      wr_op(2'd1, 32'h0000_000F); rd_chk("R3");
      chk("R3 literal", exp_reg, 32'h0000_F0FF);
      wr_op(2'd2, 32'h0000_F000); rd_chk("R4");
      chk("R4 literal", exp_reg, 32'h0000_00FF);
      wr_op(2'd3, 32'h0000_0F0F); rd_chk("R5");
      chk("R5 literal", exp_reg, 32'h0000_0FF0);

      // R6 idle hold, R7 rdata zero when not reading
      repeat (4) @(negedge clk);
      rd_chk("R6 hold");
      @(negedge clk); #1;
      chk("R7 idle rdata", bus_rdata, 32'd0);
      for (int a = 0; a < 4; a++) begin
         @(negedge clk);
         bus_addr = 2'(a); bus_rd = 1'b1; #1;
         chk("R7 alias read", bus_rdata, 32'h0000_0FF0);
         bus_rd = 1'b0;
      end

      // R8/R9/R10 soft reset and hardware clock gate
      wr_op(2'd1, 32'h8000_0000);
      for (int j = 0; j <= GD + 1; j++) begin
         rd_chk("R10 model");
         chk("R10 gate timing", {31'd0, bus_rdata[30] === 1'b1 ? 1'b1 : 1'b0},
             {31'd0, (j >= GD) ? 1'b1 : 1'b0});
         chk("R9 low zero", bus_rdata & 32'h3FFF_FFFF, 32'd0);
         chk("R8 rst high", {31'd0, core_rst}, 32'd1);
      end
      wr_op(2'd1, 32'h0000_ABCD); rd_chk("R9 ignored");
      chk("R9 literal", exp_reg, 32'hC000_0000);
      wr_op(2'd2, 32'h4000_0000);
      repeat (GD + 2) @(negedge clk);
      rd_chk("R10 once");
      chk("R10 stays clear", exp_reg, 32'h8000_0000);
      chk("R11 clk_en", {31'd0, core_clk_en}, 32'd1);

      // R12 recovery sequence
      wr_op(2'd1, 32'h4000_0000);
      wr_op(2'd2, 32'h8000_0000); rd_chk("R12 srst off");
      chk("R12 gate kept", exp_reg, 32'h4000_0000);
      wr_op(2'd2, 32'h4000_0000); rd_chk("R12 gate off");
      chk("R12 clk_en", {31'd0, core_clk_en}, 32'd1);
      wr_op(2'd0, 32'h0000_5A5A); rd_chk("R12 writable");
      chk("R12 literal", exp_reg, 32'h0000_5A5A);

      // random phase
      for (int i = 0; i < 400; i++) begin
         logic [1:0]  a;
         logic [31:0] d;
         a = 2'($urandom_range(0, 3));
         d = $urandom();
         if ($urandom_range(0, 7) != 0) d[31] = 1'b0;
         wr_op(a, d);
         case (a)
            2'd0:    rd_chk("R2 random");
            2'd1:    rd_chk("R3 random");
            2'd2:    rd_chk("R4 random");
            default: rd_chk("R5 random");
         endcase
         if ($urandom_range(0, 3) == 0) begin
            repeat ($urandom_range(1, GD + 2)) @(negedge clk);
            rd_chk("R10 random wait");
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule